// File: doc/BRIEF.md
# Up-Counting Interval Timer with Overflow Reload

This block is a general-purpose interval timer. A counter counts up by one on every clock while it runs. When the counter passes the all-ones value, the block raises an overflow event. To wait N clocks, software loads the counter with all-ones minus N. In periodic mode every overflow copies a stored reload value back into the counter, so the timer produces a steady tick. In one-shot mode the timer stops after the first overflow.

Software reaches the timer through a small register port with four word addresses. Through it software sets the run and reload flags, writes the reload value, reads or overwrites the live count, and handles a sticky overflow flag. The flag is cleared by writing one to it, and a separate enable bit gates it onto the interrupt pin. Stopping the timer keeps the count in place. Software can therefore read the count, leave the timer idle, and later write the count back and restart it.

Top module: `gp_uptimer`

## Requirements
- R1: After reset the counter, the reload value, the run and reload flags, the overflow status and the interrupt enable are all zero, and `irq` is low.
- R2: While the run flag is set, and no counter write or load strobe occurs in that cycle, the counter increases by one on each clock edge.
- R3: If the reload register holds all-ones minus N and software writes the control word with run=1 and load-strobe=1, the counter takes the reload value at that write's edge. The overflow status then becomes set at the edge N+1 clocks after the write edge, for every N from 0 up to all-ones.
- R4: An overflow while the reload flag is clear clears the run flag and leaves the counter at zero, and the counter stays there.
- R5: With the reload flag set, each overflow copies the reload register into the counter and counting continues. Loading all-ones minus (P-1) therefore gives the count sequence L, L+1, ..., all-ones, L with period P.
- R6: A cleared run flag holds the count. Reading the counter register returns the live count and has no side effect. Writing the counter register and then setting run resumes counting from the written value.
- R7: Overflow status (address 3, bit 0) stays set until a write to address 3 with bit 0 equal to one. A write with bit 0 equal to zero leaves it set. `irq` is high only while status and enable (address 3, bit 1) are both set.
- R8: If an overflow happens in the same cycle as a write-one-to-clear of the status, the status is left set.
- R9: Register map: address 0 is control, with bit 0 run, bit 1 reload, and bit 2 a load strobe that copies the reload register into the counter and always reads as zero. Address 1 is the reload value, address 2 is the live counter, and address 3 holds the status (bit 0) and the enable (bit 1). Writes take effect at the next clock edge, and reads are combinational.
- R10: A counter write or load strobe replaces that cycle's increment, even while the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr |
| irq | output | 1 | Overflow interrupt, status AND enable |

## Verification
The bench builds the timer with WIDTH set to 8. At that width every one-shot delay from zero to 255 clocks fits inside the run, so the delay check sweeps all possible load values, including the overflow on the first clock. Periodic mode is checked against an arithmetic count sequence for periods 1 through 20. The small width also makes the same-cycle overflow and clear collision, and the stop-and-resume path, cheap to set up exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_LOAD  = 2'd1,
        REG_COUNT = 2'd2,
        REG_IRQ   = 2'd3
    } tmr_reg_e;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_RELOAD = 1;
    localparam int CTRL_LDNOW  = 2;
    localparam int IRQ_STAT    = 0;
    localparam int IRQ_EN      = 1;
endpackage

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             load_we,
    input  logic             cnt_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] ld_q,
    output logic             run_q,
    output logic             rel_q,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] ld;
        logic             run;
        logic             rel;
    } core_s;

    core_s st_d, st_q;
    logic  ldnow;
    logic  tick;

    always_comb begin
        st_d  = st_q;
        ldnow = ctrl_we & wdata[CTRL_LDNOW];
        tick  = st_q.run & ~cnt_we & ~ldnow;
        ovf   = tick & (st_q.cnt == ALL_ONES);

        if (load_we) begin
            st_d.ld = wdata;
        end
        if (tick) begin
            if (ovf) begin
                if (st_q.rel) begin
                    st_d.cnt = st_q.ld;
                end else begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + WIDTH'(1);
            end
        end
        if (ctrl_we) begin
            st_d.run = wdata[CTRL_RUN];
            st_d.rel = wdata[CTRL_RELOAD];
        end
        if (ldnow) begin
            st_d.cnt = st_q.ld;
        end
        if (cnt_we) begin
            st_d.cnt = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign ld_q  = st_q.ld;
    assign run_q = st_q.run;
    assign rel_q = st_q.rel;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic irq_we,
    input  logic clr_bit,
    input  logic en_bit,
    output logic stat_q,
    output logic en_q,
    output logic irq
);
    typedef struct packed {
        logic stat;
        logic en;
    } irq_s;

    irq_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_we) begin
            st_d.en = en_bit;
            if (clr_bit) begin
                st_d.stat = 1'b0;
            end
        end
        if (ovf) begin
            st_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
    assign en_q   = st_q.en;
    assign irq    = st_q.stat & st_q.en;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] cnt_q,
    input  logic [WIDTH-1:0] ld_q,
    input  logic             run_q,
    input  logic             rel_q,
    input  logic             stat_q,
    input  logic             en_q,
    output logic [WIDTH-1:0] rdata
);
    localparam int PAD = WIDTH - 2;

    always_comb begin
        case (tmr_reg_e'(addr))
            REG_CTRL:  rdata = {{PAD{1'b0}}, rel_q, run_q};
            REG_LOAD:  rdata = ld_q;
            REG_COUNT: rdata = cnt_q;
            default:   rdata = {{PAD{1'b0}}, en_q, stat_q};
        endcase
    end
endmodule

// File: rtl/gp_uptimer.sv
module gp_uptimer
    import tmr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             irq
);
    logic             wr_en;
    logic             ctrl_we, load_we, cnt_we, irq_we;
    logic [WIDTH-1:0] cnt_q, ld_q;
    logic             run_q, rel_q, ovf, stat_q, en_q;

    assign wr_en   = bus_sel & bus_wr;
    assign ctrl_we = wr_en & (bus_addr == REG_CTRL);
    assign load_we = wr_en & (bus_addr == REG_LOAD);
    assign cnt_we  = wr_en & (bus_addr == REG_COUNT);
    assign irq_we  = wr_en & (bus_addr == REG_IRQ);

    tmr_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .load_we (load_we),
        .cnt_we  (cnt_we),
        .wdata   (bus_wdata),
        .cnt_q   (cnt_q),
        .ld_q    (ld_q),
        .run_q   (run_q),
        .rel_q   (rel_q),
        .ovf     (ovf)
    );

    tmr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .irq_we  (irq_we),
        .clr_bit (bus_wdata[IRQ_STAT]),
        .en_bit  (bus_wdata[IRQ_EN]),
        .stat_q  (stat_q),
        .en_q    (en_q),
        .irq     (irq)
    );

    tmr_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .addr   (bus_addr),
        .cnt_q  (cnt_q),
        .ld_q   (ld_q),
        .run_q  (run_q),
        .rel_q  (rel_q),
        .stat_q (stat_q),
        .en_q   (en_q),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/gp_uptimer_chk.sv
module gp_uptimer_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] count,
    input logic [WIDTH-1:0] load,
    input logic             run,
    input logic             reload,
    input logic             ovf,
    input logic             status
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic wr_any, ctrl_wr, cnt_wr, ldnow, w1c;
    assign wr_any  = bus_sel & bus_wr;
    assign ctrl_wr = wr_any & (bus_addr == 2'd0);
    assign cnt_wr  = wr_any & (bus_addr == 2'd2);
    assign ldnow   = ctrl_wr & bus_wdata[2];
    assign w1c     = wr_any & (bus_addr == 2'd3) & bus_wdata[0];

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr && !ldnow && count != TOP) |=> count == $past(count) + WIDTH'(1));

    a_r4_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reload && !ctrl_wr) |=> (count == '0 && !run));

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && reload) |=> count == $past(load));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !ldnow) |=> $stable(count));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !w1c) |=> status);

    a_r8_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> status);
endmodule

bind gp_uptimer gp_uptimer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (cnt_q),
    .load      (ld_q),
    .run       (run_q),
    .reload    (rel_q),
    .ovf       (ovf),
    .status    (stat_q)
);

// File: tb/gp_uptimer_bench.sv
`timescale 1ns/1ps
module gp_uptimer_bench;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    gp_uptimer #(.WIDTH(W)) u_gp_uptimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = W'(d);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    initial begin
        int v, k, sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset reg", v, 0);
        end
        chk("R1 irq low", int'(irq), 0);
        @(negedge clk);

        // R9 map: reload value, strobe reads zero, counter takes load
        wr(2'd1, 8'hA5);
        rd(2'd1, v); chk("R9 load reg", v, 8'hA5);
        @(negedge clk);
        wr(2'd0, 3'b110);
        rd(2'd0, v); chk("R9 ctrl readback", v, 2);
        rd(2'd2, v); chk("R9 strobe copies load", v, 8'hA5);
        @(negedge clk);
        wr(2'd0, 0);

        // R3 / R4: one-shot sweep over every load value
        for (int n = 0; n <= MAXV; n++) begin
            wr(2'd3, 3);
            wr(2'd1, MAXV - n);
            wr(2'd0, 3'b101);
            #1;
            k = 0;
            while (!irq && k < 400) begin
                @(negedge clk); #1;
                k++;
            end
            chk($sformatf("R3 delay N=%0d", n), k, n + 1);
            rd(2'd2, v); chk("R4 count at zero", v, 0);
            rd(2'd0, v); chk("R4 run cleared", v, 0);
            @(negedge clk); @(negedge clk); #1;
            rd(2'd2, v); chk("R4 count stays zero", v, 0);
            @(negedge clk);
        end

        // R5: periodic sequences
        for (int p = 1; p <= 20; p++) begin
            wr(2'd0, 0);
            wr(2'd3, 3);
            wr(2'd1, MAXV + 1 - p);
            wr(2'd0, 3'b111);
            bus_addr = 2'd2;
            for (int c = 1; c <= 3 * p; c++) begin
                @(negedge clk); #1;
                chk($sformatf("R5 period %0d step %0d", p, c), int'(bus_rdata),
                    (MAXV + 1 - p + (c % p)) & MAXV);
            end
            chk("R5 overflow flagged", int'(irq), 1);
            @(negedge clk);
        end
        wr(2'd0, 0);
        wr(2'd3, 3);

        // R2: free counting from a written value
        wr(2'd2, 8'h10);
        wr(2'd0, 1);
        bus_addr = 2'd2;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk); #1;
            chk("R2 increment", int'(bus_rdata), 8'h10 + c);
        end
        @(negedge clk);

        // R10: counter write while running replaces increment
        wr(2'd2, 8'h80);
        rd(2'd2, v); chk("R10 write replaces tick", v, 8'h80);
        @(negedge clk); #1;
        rd(2'd2, v); chk("R10 counting resumes", v, 8'h81);
        @(negedge clk);

        // R6: stop holds, read has no side effect, resume
        wr(2'd0, 0);
        rd(2'd2, sv);
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk("R6 stopped holds", v, sv);
        rd(2'd2, v); chk("R6 read no side effect", v, sv);
        @(negedge clk);
        wr(2'd2, sv);
        wr(2'd0, 1);
        @(negedge clk); @(negedge clk); @(negedge clk); #1;
        rd(2'd2, v); chk("R6 resume from saved", v, (sv + 3) & MAXV);
        @(negedge clk);
        wr(2'd0, 0);

        // R7: sticky status, W1C, enable gating
        wr(2'd3, 3);
        wr(2'd1, MAXV - 1);
        wr(2'd0, 3'b101);
        repeat (4) @(negedge clk);
        #1; chk("R7 irq raised", int'(irq), 1);
        @(negedge clk);
        wr(2'd3, 0);
        rd(2'd3, v); chk("R7 write zero keeps status", v, 1);
        chk("R7 enable gates irq", int'(irq), 0);
        @(negedge clk);
        wr(2'd3, 2);
        #1; chk("R7 enable passes irq", int'(irq), 1);
        @(negedge clk);
        wr(2'd3, 3);
        rd(2'd3, v); chk("R7 W1C clears", v, 2);
        chk("R7 irq dropped", int'(irq), 0);
        @(negedge clk);

        // R8: overflow and clear in the same cycle
        wr(2'd1, MAXV);
        wr(2'd0, 3'b101);
        wr(2'd3, 3);
        rd(2'd3, v); chk("R8 overflow beats clear", v, 3);
        @(negedge clk);
        wr(2'd3, 3);
        rd(2'd3, v); chk("R8 later clear works", v, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule